// File: doc/BRIEF.md
# Pipelined Weighted Trigger Figure-of-Merit Evaluator

This block forms a trigger decision on every clock from three unsigned integer subsystem values: a forward time-of-flight hit count `H`, a forward calorimeter energy `Ef` and a barrel calorimeter energy `Eb`. It evaluates the figure of merit `Z = a*H + b*Ef + c*(Ef+1)/(Eb+1)` in unsigned fixed point. The quotient carries 16 fractional bits and comes from a restoring divider that settles one quotient bit per pipeline stage. `Z` is compared with a programmable threshold, and a trigger bit is raised when `Z` reaches it.

The pipeline accepts a new sample on every clock and has a constant latency. The three weights and the threshold can be replaced while samples are in flight. A new set is offered on the configuration inputs and installed by a one-cycle load strobe. Each sample takes a snapshot of the set in force at the edge where it enters, and carries that snapshot down the pipe. No result ever mixes an old value with a new one.

Top module: `trig_merit_eval`

## Requirements
- R1: For every valid sample, `z_o` equals `2^16*(a*H + b*Ef) + c*floor((Ef+1)*2^16/(Eb+1))`, with all quantities unsigned. `z_o` is therefore `Z` in units of 2^-16.
- R2: A sample is taken on every rising edge where `in_valid_i` is high, with no stall. Its result appears with `out_valid_o` high after the 36th rising edge, counting the sampling edge as the first (35 edges later). Edges where `in_valid_i` is low produce cycles where `out_valid_o` is low, at the same offset.
- R3: The ratio term is the exact floor quotient, including the extremes `Eb = 0` (divisor 1) and `Eb = 65535` (divisor 65536) and `Ef = 65535`.
- R4: `trig_o` is high exactly when `out_valid_o` is high and `z_o` is greater than or equal to the threshold. The threshold is expressed in the same 2^-16 units as `z_o`, so equality triggers.
- R5: `trig_o` is low in every cycle where `out_valid_o` is low.
- R6: When the exact sum exceeds 2^48-1, `z_o` is 2^48-1 instead of a wrapped value.
- R7: When `cfg_load_i` is high at an edge, all four configuration values are installed together at that edge. A sample taken at that same edge still uses the previous set, and samples taken later use the new set. Configuration values presented without `cfg_load_i` have no effect on any result.
- R8: After reset, `out_valid_o` and `trig_o` are low. The active weights are zero and the active threshold is 2^48-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Sample present on this edge |
| tof_hits_i | input | 16 | Forward time-of-flight hit count H |
| fcal_e_i | input | 16 | Forward calorimeter energy Ef |
| bcal_e_i | input | 16 | Barrel calorimeter energy Eb |
| cfg_load_i | input | 1 | Install the offered configuration set at this edge |
| cfg_tof_w_i | input | 16 | Offered weight a |
| cfg_fcal_w_i | input | 16 | Offered weight b |
| cfg_ratio_w_i | input | 16 | Offered weight c |
| cfg_thr_i | input | 48 | Offered threshold, units of 2^-16 |
| out_valid_o | output | 1 | Result valid |
| z_o | output | 48 | Saturated figure of merit, units of 2^-16 |
| trig_o | output | 1 | Trigger decision |

## Verification
The two functions that can fall in the same cycle are the acceptance of a sample and the installation of a new configuration set. The bench raises the load strobe on the same edge as a valid sample whose result differs under the old and new sets. It also loads while earlier samples are still in the divider, and it offers changed values without a load. A second collision pits saturation against the threshold compare: with the threshold at 2^48-1, only a saturated sum can trigger. A behavioural model keeps its own active set and queue of expected results, and it is compared with the outputs on every clock.

// File: rtl/trig_merit_pkg.sv
package trig_merit_pkg;
    localparam int unsigned IN_W   = 16;
    localparam int unsigned W_W    = 16;
    localparam int unsigned FRAC_W = 16;
    localparam int unsigned Z_W    = 48;

    localparam int unsigned NUM_W  = IN_W + 1 + FRAC_W;
    localparam int unsigned DEN_W  = IN_W + 1;
    localparam int unsigned LIN_W  = IN_W + W_W + 1;
    localparam int unsigned LINS_W = LIN_W + FRAC_W;
    localparam int unsigned PROD_W = W_W + NUM_W;
    localparam int unsigned SUM_W  = ((LINS_W > PROD_W) ? LINS_W : PROD_W) + 1;

    typedef struct packed {
        logic [W_W-1:0] tof_w;
        logic [W_W-1:0] fcal_w;
        logic [W_W-1:0] ratio_w;
        logic [Z_W-1:0] thr;
    } coef_set_t;

    typedef struct packed {
        logic [LIN_W-1:0] lin;
        logic [W_W-1:0]   ratio_w;
        logic [Z_W-1:0]   thr;
    } side_t;

    localparam int unsigned SIDE_W = $bits(side_t);
endpackage

// File: rtl/trig_coef_bank.sv
module trig_coef_bank
    import trig_merit_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      load_i,
    input  coef_set_t next_i,
    output coef_set_t act_o
);
    coef_set_t act_d, act_q;

    always_comb begin
        act_d = act_q;
        if (load_i) begin
            act_d = next_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q.tof_w   <= '0;
            act_q.fcal_w  <= '0;
            act_q.ratio_w <= '0;
            act_q.thr     <= '1;
        end else begin
            act_q <= act_d;
        end
    end

    assign act_o = act_q;

    // R7: a load installs the whole offered set at once
    a_r7_load_installs: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> act_q == $past(next_i));

    // R7: without a load the active set does not move
    a_r7_hold_without_load: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(act_q));
endmodule

// File: rtl/trig_pipe_div.sv
module trig_pipe_div #(
    parameter int unsigned NUM_W  = 33,
    parameter int unsigned DEN_W  = 17,
    parameter int unsigned SIDE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic [NUM_W-1:0]  num_i,
    input  logic [DEN_W-1:0]  den_i,
    input  logic [SIDE_W-1:0] side_i,
    output logic              valid_o,
    output logic [NUM_W-1:0]  quo_o,
    output logic [SIDE_W-1:0] side_o
);
    typedef struct packed {
        logic              vld;
        logic [DEN_W-1:0]  rem;
        logic [NUM_W-1:0]  acc;
        logic [DEN_W-1:0]  den;
        logic [SIDE_W-1:0] side;
    } stage_t;

    stage_t in_s;
    stage_t st_d [NUM_W];
    stage_t st_q [NUM_W];

    always_comb begin
        in_s.vld  = valid_i;
        in_s.rem  = '0;
        in_s.acc  = num_i;
        in_s.den  = den_i;
        in_s.side = side_i;
    end

    always_comb begin
        stage_t          prev;
        logic [DEN_W:0]  trial;
        logic            ge;
        prev = in_s;
        for (int i = 0; i < NUM_W; i++) begin
            trial       = {prev.rem, prev.acc[NUM_W-1]};
            ge          = (trial >= {1'b0, prev.den});
            st_d[i]     = prev;
            st_d[i].rem = ge ? DEN_W'(trial - {1'b0, prev.den}) : DEN_W'(trial);
            st_d[i].acc = {prev.acc[NUM_W-2:0], ge};
            prev        = st_q[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_W; i++) begin
                st_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < NUM_W; i++) begin
                st_q[i] <= st_d[i];
            end
        end
    end

    assign valid_o = st_q[NUM_W-1].vld;
    assign quo_o   = st_q[NUM_W-1].acc;
    assign side_o  = st_q[NUM_W-1].side;

    for (genvar g = 0; g < NUM_W; g++) begin : g_chk
        // R3: every partial remainder stays below its divisor
        a_r3_rem_below_den: assert property (@(posedge clk) disable iff (!rst_n)
            st_q[g].vld |-> st_q[g].rem < st_q[g].den);
        if (g == 0) begin : g_first
            // R2: valid advances one stage per clock, no stall
            a_r2_valid_step: assert property (@(posedge clk) disable iff (!rst_n)
                st_q[g].vld == $past(valid_i));
        end else begin : g_rest
            a_r2_valid_step: assert property (@(posedge clk) disable iff (!rst_n)
                st_q[g].vld == $past(st_q[g-1].vld));
        end
    end
endmodule

// File: rtl/trig_merit_fold.sv
module trig_merit_fold
    import trig_merit_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid_i,
    input  logic [NUM_W-1:0] quo_i,
    input  side_t            side_i,
    output logic             valid_o,
    output logic [Z_W-1:0]   z_o,
    output logic             trig_o
);
    localparam logic [SUM_W-1:0] Z_MAX = SUM_W'({Z_W{1'b1}});

    typedef struct packed {
        logic              m1_vld;
        logic [LINS_W-1:0] m1_lin;
        logic [PROD_W-1:0] m1_prod;
        logic [Z_W-1:0]    m1_thr;
        logic              m2_vld;
        logic [Z_W-1:0]    m2_z;
        logic              m2_trig;
    } fold_t;

    fold_t            fold_d, fold_q;
    logic [SUM_W-1:0] sum_w;
    logic [Z_W-1:0]   z_sat;

    always_comb begin
        fold_d         = fold_q;
        fold_d.m1_vld  = valid_i;
        fold_d.m1_lin  = {side_i.lin, {FRAC_W{1'b0}}};
        fold_d.m1_prod = PROD_W'(side_i.ratio_w) * PROD_W'(quo_i);
        fold_d.m1_thr  = side_i.thr;

        sum_w = SUM_W'(fold_q.m1_lin) + SUM_W'(fold_q.m1_prod);
        z_sat = (sum_w > Z_MAX) ? {Z_W{1'b1}} : Z_W'(sum_w);

        fold_d.m2_vld  = fold_q.m1_vld;
        fold_d.m2_z    = z_sat;
        fold_d.m2_trig = fold_q.m1_vld && (z_sat >= fold_q.m1_thr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fold_q <= '0;
        end else begin
            fold_q <= fold_d;
        end
    end

    assign valid_o = fold_q.m2_vld;
    assign z_o     = fold_q.m2_z;
    assign trig_o  = fold_q.m2_trig;

    // R6: an overflowing sum leaves the stage pinned at full scale
    a_r6_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (fold_q.m1_vld && (sum_w > Z_MAX)) |=> (fold_q.m2_z == {Z_W{1'b1}}));
endmodule

// File: rtl/trig_merit_eval.sv
module trig_merit_eval
    import trig_merit_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid_i,
    input  logic [IN_W-1:0]  tof_hits_i,
    input  logic [IN_W-1:0]  fcal_e_i,
    input  logic [IN_W-1:0]  bcal_e_i,
    input  logic             cfg_load_i,
    input  logic [W_W-1:0]   cfg_tof_w_i,
    input  logic [W_W-1:0]   cfg_fcal_w_i,
    input  logic [W_W-1:0]   cfg_ratio_w_i,
    input  logic [Z_W-1:0]   cfg_thr_i,
    output logic             out_valid_o,
    output logic [Z_W-1:0]   z_o,
    output logic             trig_o
);
    typedef struct packed {
        logic             vld;
        logic [NUM_W-1:0] num;
        logic [DEN_W-1:0] den;
        side_t            side;
    } entry_t;

    coef_set_t        cfg_next, cfg_act;
    entry_t           entry_d, entry_q;
    logic             div_vld;
    logic [NUM_W-1:0] div_quo;
    logic [SIDE_W-1:0] div_side;

    always_comb begin
        cfg_next.tof_w   = cfg_tof_w_i;
        cfg_next.fcal_w  = cfg_fcal_w_i;
        cfg_next.ratio_w = cfg_ratio_w_i;
        cfg_next.thr     = cfg_thr_i;
    end

    trig_coef_bank u_coef (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (cfg_load_i),
        .next_i (cfg_next),
        .act_o  (cfg_act)
    );

    always_comb begin
        entry_d              = entry_q;
        entry_d.vld          = in_valid_i;
        entry_d.num          = {DEN_W'(fcal_e_i) + DEN_W'(1), {FRAC_W{1'b0}}};
        entry_d.den          = DEN_W'(bcal_e_i) + DEN_W'(1);
        entry_d.side.lin     = LIN_W'(cfg_act.tof_w)  * LIN_W'(tof_hits_i)
                             + LIN_W'(cfg_act.fcal_w) * LIN_W'(fcal_e_i);
        entry_d.side.ratio_w = cfg_act.ratio_w;
        entry_d.side.thr     = cfg_act.thr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            entry_q <= '0;
        end else begin
            entry_q <= entry_d;
        end
    end

    trig_pipe_div #(
        .NUM_W  (NUM_W),
        .DEN_W  (DEN_W),
        .SIDE_W (SIDE_W)
    ) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid_i (entry_q.vld),
        .num_i   (entry_q.num),
        .den_i   (entry_q.den),
        .side_i  (entry_q.side),
        .valid_o (div_vld),
        .quo_o   (div_quo),
        .side_o  (div_side)
    );

    trig_merit_fold u_fold (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid_i (div_vld),
        .quo_i   (div_quo),
        .side_i  (side_t'(div_side)),
        .valid_o (out_valid_o),
        .z_o     (z_o),
        .trig_o  (trig_o)
    );

    // R5: no trigger without a valid result
    a_r5_trig_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        trig_o |-> out_valid_o);

    // R3: the divider never sees a zero divisor
    a_r3_den_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        entry_q.vld |-> entry_q.den != '0);
endmodule

// File: tb/trig_merit_eval_tb.sv
module trig_merit_eval_tb;
    localparam int LAT = 36;
    localparam logic [47:0] ZMAX = 48'hFFFF_FFFF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid_i;
    logic [15:0] tof_hits_i, fcal_e_i, bcal_e_i;
    logic        cfg_load_i;
    logic [15:0] cfg_tof_w_i, cfg_fcal_w_i, cfg_ratio_w_i;
    logic [47:0] cfg_thr_i;
    logic        out_valid_o;
    logic [47:0] z_o;
    logic        trig_o;

    int checks = 0;
    int errors = 0;
    string cur_tag = "R1";

    typedef struct {
        bit          vld;
        logic [47:0] z;
        bit          trig;
        string       tag;
    } exp_t;
    exp_t q[$];

    longint unsigned m_a, m_b, m_c;
    logic [47:0]     m_thr;

    always #2 clk = ~clk;

    trig_merit_eval u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid_i),
        .tof_hits_i(tof_hits_i), .fcal_e_i(fcal_e_i), .bcal_e_i(bcal_e_i),
        .cfg_load_i(cfg_load_i), .cfg_tof_w_i(cfg_tof_w_i),
        .cfg_fcal_w_i(cfg_fcal_w_i), .cfg_ratio_w_i(cfg_ratio_w_i),
        .cfg_thr_i(cfg_thr_i), .out_valid_o(out_valid_o), .z_o(z_o),
        .trig_o(trig_o)
    );

    function automatic logic [47:0] model_z(longint unsigned h, longint unsigned ef,
                                            longint unsigned eb, longint unsigned a,
                                            longint unsigned b, longint unsigned c);
        longint unsigned ratio, tot;
        ratio = ((ef + 1) << 16) / (eb + 1);
        tot   = ((a * h + b * ef) << 16) + c * ratio;
        if (tot > 64'(ZMAX)) return ZMAX;
        return 48'(tot);
    endfunction

    task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, expv, $time);
        end
    endtask

    // reference model: one entry per edge, active set updated after use
    always @(posedge clk) begin
        if (!rst_n) begin
            q.delete();
            m_a = 0; m_b = 0; m_c = 0; m_thr = ZMAX;
        end else begin
            exp_t e;
            e.vld  = in_valid_i;
            e.z    = model_z(tof_hits_i, fcal_e_i, bcal_e_i, m_a, m_b, m_c);
            e.trig = in_valid_i && (e.z >= m_thr);
            e.tag  = cur_tag;
            q.push_front(e);
            if (q.size() > LAT) void'(q.pop_back());
            if (cfg_load_i) begin
                m_a = cfg_tof_w_i; m_b = cfg_fcal_w_i; m_c = cfg_ratio_w_i;
                m_thr = cfg_thr_i;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && q.size() == LAT) begin
            exp_t e;
            e = q[LAT-1];
            chk(out_valid_o == e.vld, "R2", 64'(out_valid_o), 64'(e.vld));
            if (e.vld) begin
                chk(z_o == e.z, e.tag, 64'(z_o), 64'(e.z));
                chk(trig_o == e.trig, (e.tag == "R1") ? "R4" : e.tag, 64'(trig_o), 64'(e.trig));
            end else begin
                chk(trig_o == 1'b0, "R5", 64'(trig_o), 64'd0);
            end
        end
    end

    task automatic put(bit v, int h, int ef, int eb, bit ld, string tag);
        @(negedge clk);
        in_valid_i = v;
        tof_hits_i = 16'(h); fcal_e_i = 16'(ef); bcal_e_i = 16'(eb);
        cfg_load_i = ld;
        cur_tag    = tag;
    endtask

    task automatic offer(int a, int b, int c, logic [47:0] thr);
        cfg_tof_w_i = 16'(a); cfg_fcal_w_i = 16'(b); cfg_ratio_w_i = 16'(c);
        cfg_thr_i = thr;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual running expected done");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; in_valid_i = 1'b0; cfg_load_i = 1'b0;
        tof_hits_i = '0; fcal_e_i = '0; bcal_e_i = '0;
        offer(0, 0, 0, '0);
        repeat (5) @(negedge clk);
        // R8: reset state at the ports
        chk(out_valid_o == 1'b0, "R8", 64'(out_valid_o), 0);
        chk(trig_o == 1'b0, "R8", 64'(trig_o), 0);
        rst_n = 1'b1;

        // R8: reset weights zero, threshold full scale
        for (int i = 0; i < 4; i++) put(1, 1000 + i, 2000, 3, 0, "R8");
        // R7: offered values without a load change nothing
        offer(9, 9, 9, 48'd0);
        for (int i = 0; i < 4; i++) put(1, 500, 700 + i, 10, 0, "R7");

        // R1: dense stream under one set
        offer(3, 2, 5, 48'(200000) << 16);
        put(0, 0, 0, 0, 1, "R1");
        for (int i = 0; i < 200; i++)
            put(1, int'($urandom_range(0, 65535)), int'($urandom_range(0, 65535)),
                int'($urandom_range(0, 65535)), 0, "R1");

        // R3: divisor extremes
        put(1, 0, 65535, 0, 0, "R3");
        put(1, 0, 0, 65535, 0, "R3");
        put(1, 7, 65535, 65535, 0, "R3");
        put(1, 1, 12345, 1, 0, "R3");

        // R2: bubbles between samples
        for (int i = 0; i < 20; i++) put(i % 3 == 0, 40 * i, 11 * i, i, 0, "R2");

        // R4: equality at the threshold and one below
        offer(1, 0, 0, 48'(100) << 16);
        put(0, 0, 0, 0, 1, "R4");
        put(1, 100, 5, 5, 0, "R4");
        put(1, 99, 5, 5, 0, "R4");
        put(1, 101, 5, 5, 0, "R4");

        // R6: saturation meets a full-scale threshold
        offer(65535, 65535, 65535, ZMAX);
        put(0, 0, 0, 0, 1, "R6");
        put(1, 65535, 65535, 0, 0, "R6");
        put(1, 65535, 0, 65535, 0, "R6");

        // R7: load on the same edge as a sample, then samples after it
        offer(2, 0, 0, 48'(10) << 16);
        put(1, 4, 0, 0, 0, "R7");
        offer(10, 1, 1, 48'(30) << 16);
        put(1, 4, 0, 0, 1, "R7");
        put(1, 4, 0, 0, 0, "R7");
        put(1, 3, 0, 0, 0, "R7");

        // R7: loads landing while samples are in flight
        for (int i = 0; i < 300; i++) begin
            bit ld = ($urandom_range(0, 15) == 0);
            if (ld) offer(int'($urandom_range(0, 65535)), int'($urandom_range(0, 65535)),
                          int'($urandom_range(0, 65535)),
                          48'($urandom_range(0, 32'hFFFF_FFFF)) << 12);
            put(int'($urandom_range(0, 3) != 0), int'($urandom_range(0, 65535)),
                int'($urandom_range(0, 65535)), int'($urandom_range(0, 65535)), ld, "R7");
        end

        put(0, 0, 0, 0, 0, "R2");
        repeat (LAT + 4) @(negedge clk);
        finish_run();
    end
endmodule